// File: doc/BRIEF.md
# External Interrupt Request Latch

This block gathers external interrupt requests from two kinds of source into one pending flag for the CPU. The first source is a dedicated interrupt pin that is active-low. The second is a group of general port pins. A configuration input can turn the port pins into extra interrupt inputs. When it does, the port pins are OR-combined and use the same pending flag as the dedicated pin. The block first synchronizes every pin and then detects edges on each one. A single trigger-mode input sets how both kinds of source are qualified. In edge-only mode, only transitions set the flag. In edge-and-level mode, a held active level also sets it, so several wired-OR sources can share one pin.

The CPU sees a request only while the flag is set, its global mask bit is clear and the interrupt-enable bit is set. The CPU clears the flag with a one-cycle acknowledge strobe when it fetches the vector, so a request that arrives during the service routine is caught again. While port interrupts are enabled and any port pin is high, the dedicated pin is ignored completely. A falling edge that happens during that time is lost.

Top module: `ext_irq_latch`

## Requirements
- R1: Reset clears the pending flag and drops `irq_req`. During reset the edge history loads the current synchronized pin levels, so a dedicated pin held low through reset does not latch a request afterwards in edge-only mode.
- R2: While `port_irq_en` is 0, the port pins never set the pending flag, and they do not block the dedicated pin.
- R3: While `port_irq_en` is 1, a 0-to-1 transition on any of the port pins sets the pending flag.
- R4: In edge-only mode (`level_mode` = 0), a port pin that stays high after the flag is acknowledged does not set the flag again. That pin must go low and then high again.
- R5: In edge-and-level mode (`level_mode` = 1), while port interrupts are enabled, any port pin at 1 keeps setting the flag, so an acknowledge does not clear it.
- R6: A 1-to-0 transition on `irq_n` sets the flag. In edge-and-level mode, `irq_n` held at 0 also sets it. In edge-only mode, a held 0 does not set the flag again after an acknowledge.
- R7: While `port_irq_en` is 1 and any port pin is 1, `irq_n` transitions and levels have no effect. An `irq_n` fall during that time is not recovered once the port pins return low.
- R8: `irq_req` is 1 exactly when the flag is set, `cpu_mask` is 0 and `irq_enable` is 1.
- R9: `vec_ack` clears the flag on the next clock edge. If a qualifying edge or level is present at that same edge, the set wins and the flag stays 1.
- R10: A pin change applied between two clock edges reaches `irq_req` after the third rising edge that follows it. There are two synchronizer stages and then the flag register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 1 | Dedicated active-low interrupt pin |
| port_pin | input | 4 | Port pins usable as interrupt sources (active high) |
| port_irq_en | input | 1 | 1 = port pins act as interrupt sources |
| level_mode | input | 1 | 0 = edge-only, 1 = edge-and-level, for both source kinds |
| cpu_mask | input | 1 | CPU global interrupt mask, 1 = masked |
| irq_enable | input | 1 | External interrupt enable, 1 = enabled |
| vec_ack | input | 1 | One-cycle strobe when the CPU fetches the vector; clears the flag |
| irq_req | output | 1 | Gated interrupt request to the CPU |

## Verification
The bench targets the lockout of the dedicated pin. It drops `irq_n` while a port pin is high, then releases the port pins. A design that only delays the dedicated pin, instead of ignoring it, would raise a late request at that point. It also holds pins at their active level across an acknowledge in both trigger modes. A design that confuses level with edge would either re-request forever in edge-only mode or lose wired-OR requests in level mode. Finally, it sets a new edge in the same cycle as the acknowledge and holds `irq_n` low through reset. Putting the clear before the set would drop the first request, and resetting the edge history to idle values would create a false request after reset.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  // Trigger qualification shared by the dedicated pin and the port pins.
  typedef enum logic {
    TRIG_EDGE       = 1'b0,
    TRIG_EDGE_LEVEL = 1'b1
  } trig_e;

  // Per-cycle qualification result handed from the qualifier to the flag.
  typedef struct packed {
    logic port_set;   // port group asks to set the flag
    logic dpin_set;   // dedicated pin asks to set the flag
    logic port_blk;   // port group is locking out the dedicated pin
  } qual_t;

endpackage

// File: rtl/eil_sync.sv
module eil_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/eil_qualify.sv
module eil_qualify
  import ext_irq_pkg::*;
#(
  parameter int NUM_PORT = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dpin_n_s,   // synchronized dedicated pin, active low
  input  logic [NUM_PORT-1:0] port_s,     // synchronized port pins
  input  logic                port_en,
  input  trig_e               mode,
  output qual_t               qual
);

  logic                dpin_prev;
  logic [NUM_PORT-1:0] port_prev;

  // Edge history follows the pins; during reset it loads the present levels.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dpin_prev <= dpin_n_s;
      port_prev <= port_s;
    end else begin
      dpin_prev <= dpin_n_s;
      port_prev <= port_s;
    end
  end

  function automatic logic any_rise(input logic [NUM_PORT-1:0] cur,
                                    input logic [NUM_PORT-1:0] old);
    return |(cur & ~old);
  endfunction

  function automatic logic fell(input logic cur, input logic old);
    return old & ~cur;
  endfunction

  function automatic logic qualify(input logic edge_hit, input logic level_hit,
                                   input trig_e m);
    return edge_hit | ((m == TRIG_EDGE_LEVEL) & level_hit);
  endfunction

  logic port_rise_w, port_high_w, dpin_fall_w, dpin_low_w;

  assign port_rise_w = port_en & any_rise(port_s, port_prev);
  assign port_high_w = port_en & (|port_s);
  assign dpin_fall_w = fell(dpin_n_s, dpin_prev);
  assign dpin_low_w  = ~dpin_n_s;

  always_comb begin
    qual.port_blk = port_high_w;
    qual.port_set = qualify(port_rise_w, port_high_w, mode);
    qual.dpin_set = ~port_high_w & qualify(dpin_fall_w, dpin_low_w, mode);
  end

  // R3: an enabled rising port pin always yields a set request
  a_r3_port_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && ((port_s & ~port_prev) != '0)) |-> qual.port_set);

  // R2: disabled port pins neither set nor block
  a_r2_port_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |-> (!qual.port_set && !qual.port_blk));

endmodule

// File: rtl/eil_flag.sv
module eil_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend_q <= 1'b0;
    else if (set_i) pend_q <= 1'b1;
    else if (clr_i) pend_q <= 1'b0;
  end

  // R9: set has priority over the vector-fetch clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> pend_q);

  // R9: acknowledge with no new set clears the flag
  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !pend_q);

  // R9: without set or clear the flag holds
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(pend_q));

endmodule

// File: rtl/ext_irq_latch.sv
module ext_irq_latch
  import ext_irq_pkg::*;
#(
  parameter int NUM_PORT    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                irq_n,
  input  logic [NUM_PORT-1:0] port_pin,
  input  logic                port_irq_en,
  input  logic                level_mode,
  input  logic                cpu_mask,
  input  logic                irq_enable,
  input  logic                vec_ack,
  output logic                irq_req
);

  localparam int SW = NUM_PORT + 1;

  logic [SW-1:0]       sync_q;
  logic                dpin_n_s;
  logic [NUM_PORT-1:0] port_s;
  qual_t               qual;
  logic                flag_set;
  logic                pend;

  eil_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   ({irq_n, port_pin}),
    .q   (sync_q)
  );

  assign dpin_n_s = sync_q[SW-1];
  assign port_s   = sync_q[NUM_PORT-1:0];

  eil_qualify #(.NUM_PORT(NUM_PORT)) u_qual (
    .clk      (clk),
    .rst_n    (rst_n),
    .dpin_n_s (dpin_n_s),
    .port_s   (port_s),
    .port_en  (port_irq_en),
    .mode     (trig_e'(level_mode)),
    .qual     (qual)
  );

  assign flag_set = qual.port_set | qual.dpin_set;

  eil_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (flag_set),
    .clr_i  (vec_ack),
    .pend_q (pend)
  );

  assign irq_req = pend & ~cpu_mask & irq_enable;

  // R7: dedicated pin cannot set the flag during port lockout
  a_r7_lockout: assert property (@(posedge clk) disable iff (!rst_n)
    qual.port_blk |-> !qual.dpin_set);

  // R8: request only with mask clear and enable set
  a_r8_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (!cpu_mask && irq_enable));

  // R1: request low in the first cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> !irq_req);

endmodule

// File: tb/ext_irq_latch_test.sv
`timescale 1ns/1ps
module ext_irq_latch_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       irq_n;
  logic [3:0] port_pin;
  logic       port_irq_en, level_mode, cpu_mask, irq_enable, vec_ack;
  logic       irq_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  ext_irq_latch uut (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .port_pin(port_pin),
    .port_irq_en(port_irq_en), .level_mode(level_mode), .cpu_mask(cpu_mask),
    .irq_enable(irq_enable), .vec_ack(vec_ack), .irq_req(irq_req)
  );

  // Row: [10]port_en [9]level [8]irq_n [7:4]port [3]ack pulse [2]mask [1]enable [0]expected
  localparam int NV = 26;
  localparam logic [10:0] VEC [NV] = '{
    11'b0_0_1_0000_0_0_1_0, // R1 idle
    11'b0_0_1_0101_0_0_1_0, // R2 disabled port rise
    11'b0_0_0_0101_0_0_1_1, // R2 R6 fall not blocked
    11'b0_0_0_0101_1_0_1_0, // R6 edge: held low no relatch
    11'b0_0_1_0000_0_0_1_0, // R2
    11'b1_0_1_0000_0_0_1_0, // R3 enable, idle
    11'b1_0_1_0100_0_0_1_1, // R3 rise pin2
    11'b1_0_1_0100_1_0_1_0, // R4 held high no relatch
    11'b1_0_1_0110_0_0_1_1, // R3 rise pin1
    11'b1_0_1_0110_1_0_1_0, // R4
    11'b1_0_0_0110_0_0_1_0, // R7 fall blocked
    11'b1_0_0_0000_0_0_1_0, // R7 lost after release
    11'b1_0_1_0000_0_0_1_0, // R6 idle
    11'b1_0_0_0000_0_0_1_1, // R6 fall
    11'b1_0_0_0000_1_0_1_0, // R6 ack clears
    11'b1_1_0_0000_0_0_1_1, // R6 level low
    11'b1_1_0_0000_1_0_1_1, // R6 R9 level relatch beats ack
    11'b1_1_0_1000_1_0_1_1, // R5 port level holds
    11'b1_1_1_0000_1_0_1_0, // R5 release, ack clears
    11'b1_1_1_0001_0_1_1_0, // R8 masked
    11'b1_1_1_0001_0_0_0_0, // R8 disabled
    11'b1_1_1_0001_0_0_1_1, // R8 pass
    11'b1_1_1_0000_1_0_1_0, // R5 release and ack
    11'b0_1_1_1111_0_0_1_0, // R2 disabled port level
    11'b0_1_0_1111_0_0_1_1, // R2 no lockout when disabled
    11'b0_1_1_1111_1_0_1_0  // R2
  };
  localparam int VREQ [NV] = '{1,2,2,6,2,3,3,4,3,4,7,7,6,6,6,6,9,5,5,8,8,8,5,2,2,2};

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: irq_req=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; irq_n = 1'b1; port_pin = '0; port_irq_en = 1'b0;
    level_mode = 1'b0; cpu_mask = 1'b0; irq_enable = 1'b1; vec_ack = 1'b0;
    tick(5);
    check("R1 in reset", irq_req, 1'b0);
    rst_n = 1'b1;
    tick(4);
    check("R1 after reset", irq_req, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [10:0] v;
      v = VEC[i];
      port_irq_en = v[10]; level_mode = v[9]; irq_n = v[8];
      port_pin = v[7:4]; cpu_mask = v[2]; irq_enable = v[1];
      tick(4);
      if (v[3]) begin
        vec_ack = 1'b1;
        tick(1);
        vec_ack = 1'b0;
        tick(3);
      end
      check($sformatf("R%0d row %0d", VREQ[i], i), irq_req, v[0]);
    end

    // R10: latency of three edges from a port rise
    port_irq_en = 1'b1; level_mode = 1'b0; irq_n = 1'b1; port_pin = '0;
    cpu_mask = 1'b0; irq_enable = 1'b1;
    tick(4);
    port_pin = 4'b0001;
    tick(2);
    check("R10 not yet after two edges", irq_req, 1'b0);
    tick(1);
    check("R10 set after third edge", irq_req, 1'b1);

    // R9: new edge in the acknowledge cycle keeps the flag set
    port_pin = 4'b0011;
    tick(2);
    vec_ack = 1'b1;
    tick(1);
    vec_ack = 1'b0;
    check("R9 set wins over ack", irq_req, 1'b1);
    tick(3);
    check("R9 still set", irq_req, 1'b1);
    vec_ack = 1'b1;
    tick(1);
    vec_ack = 1'b0;
    check("R9 plain ack clears", irq_req, 1'b0);

    // R1: reset with a set flag, and dedicated pin held low through reset
    port_pin = 4'b0100;
    tick(4);
    check("R3 flag set before reset", irq_req, 1'b1);
    port_pin = '0; port_irq_en = 1'b0; irq_n = 1'b0;
    rst_n = 1'b0;
    tick(1);
    check("R1 reset drops request", irq_req, 1'b0);
    tick(4);
    rst_n = 1'b1;
    tick(6);
    check("R1 low pin through reset not latched", irq_req, 1'b0);

    finish_run();
  end

endmodule